// File: doc/BRIEF.md
# Spectral Pixel Inner-Product Classifier

This block scores one spectral pixel against a classification vector held in on-chip registers. A host processor drives it through a small memory-mapped register port. The host loads the signed coefficient vector once, and that vector then serves every pixel that follows. For each pixel, the host writes the unsigned band samples into a staging bank. It then issues a store command, which latches those samples as the working pixel. A separate multiply command sums the band-by-band products of the working pixel and the coefficient vector.

The block does nothing until the host sets the go bit in the control register. A ready flag tells the host when the next command may be issued. The multiply uses a single multiply-accumulate stage and handles one band per clock. When it finishes, the full-precision signed sum lands in a result register that the host can read but not write, and a done flag is raised. A go bit written while the block is busy is dropped and records a sticky error.

Top module: `pixel_dot_classifier`

## Requirements
- R1: A synchronous reset leaves the block in this state: control reads 0x2 (ready only), the result reads 0, the working pixel reads 0, and the coefficients read 0.
- R2: Addresses are decoded from the top two address bits, with i taken from the low bits. Region 0 holds the control register at 0 and the result at 1. Region 1 (0x10+i for N=16) accepts staging writes and reads back working pixel band i. Region 2 (0x20+i) writes and reads coefficient i.
- R3: Control write bits: bit0 is go, bit1 selects multiply (1) or store (0), and bit2 written as 1 clears the error flag. Control read bits: bit0 pending go, bit1 ready, bit2 error, bit3 done.
- R4: A store command copies every staging sample into the working pixel. Staging writes made without a store do not change the working pixel or the next multiply result.
- R5: A multiply command produces the sum over all N bands of the unsigned 12-bit pixel sample times the signed 16-bit coefficient. The result is 32-bit two's complement and exact at the extreme operand values.
- R6: After a go write for a store, ready is low for exactly 1 cycle. After a go write for a multiply, ready is low for exactly N+1 cycles.
- R7: The go bit reads 1 in the cycle after an accepted go write and 0 in the cycle after that.
- R8: A go write that arrives while ready is low is ignored and sets the error flag. The error flag stays set until 1 is written to control bit2.
- R9: The done flag sets when a multiply completes and stays set through control reads. A read of the result address clears it.
- R10: Writes to the result address have no effect on the result.
- R11: Coefficient writes made while ready is low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe (side effect: clears done on a result read) |
| rd_addr | input | 6 | Read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |

## Verification
The multiply is exercised with a table of affine pixel and coefficient patterns:
- An all-zero pixel shows that stale accumulator state does not leak into the result.
- A ramp against unit weights checks band indexing.
- Saturated pixels against the most positive and the most negative coefficient confirm the width and sign of the sum.
- Wrapping ramps with mixed signs check the sign extension of each product.

Directed cases separate the store and multiply commands, measure the exact ready-low window, and show that a go write or coefficient write during busy time leaves the outcome unchanged.

// File: rtl/pixel_dot_classifier.sv
module pixel_dot_classifier #(
  parameter  int N      = 16,
  parameter  int PIX_W  = 12,
  parameter  int COEF_W = 16,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
  localparam int AW     = IDX_W + 2,
  localparam int ACC_W  = PIX_W + COEF_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [ACC_W-1:0]  rd_data
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);
  localparam logic [AW-1:0]    A_CTRL = '0;
  localparam logic [AW-1:0]    A_RES  = AW'(1);

  logic [PIX_W-1:0]         stage [N];
  logic [PIX_W-1:0]         pix   [N];
  logic signed [COEF_W-1:0] coef  [N];
  logic                     go_q, op_q, mul_busy, err, done;
  logic [IDX_W-1:0]         cnt;
  logic signed [ACC_W-1:0]  acc, result, prod;

  wire [1:0]       wreg  = wr_addr[AW-1:AW-2];
  wire [IDX_W-1:0] widx  = wr_addr[IDX_W-1:0];
  wire [1:0]       rreg  = rd_addr[AW-1:AW-2];
  wire [IDX_W-1:0] ridx  = rd_addr[IDX_W-1:0];
  wire ready    = !go_q && !mul_busy;
  wire ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  wire go_req   = ctrl_wr && wr_data[0];
  wire mul_last = mul_busy && (cnt == LAST);

  assign prod = ACC_W'($signed({1'b0, pix[cnt]})) * ACC_W'(coef[cnt]);

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q <= 1'b0; op_q <= 1'b0; mul_busy <= 1'b0;
      err <= 1'b0; done <= 1'b0; cnt <= '0;
      acc <= '0; result <= '0;
      for (int i = 0; i < N; i++) begin
        stage[i] <= '0; pix[i] <= '0; coef[i] <= '0;
      end
    end else begin
      go_q <= go_req && ready;
      if (go_req && ready) op_q <= wr_data[1];

      if (go_req && !ready) err <= 1'b1;
      else if (ctrl_wr && wr_data[2]) err <= 1'b0;

      if (rd_en && rd_addr == A_RES) done <= 1'b0;

      if (go_q) begin
        if (op_q) begin
          mul_busy <= 1'b1;
          cnt      <= '0;
          acc      <= '0;
        end else begin
          for (int i = 0; i < N; i++) pix[i] <= stage[i];
        end
      end

      if (mul_busy) begin
        acc <= acc + prod;
        cnt <= cnt + 1'b1;
        if (mul_last) begin
          mul_busy <= 1'b0;
          result   <= acc + prod;
          done     <= 1'b1;
        end
      end

      if (wr_en && wreg == 2'd1 && int'(widx) < N)
        stage[widx] <= wr_data[PIX_W-1:0];
      if (wr_en && wreg == 2'd2 && int'(widx) < N && ready)
        coef[widx] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rreg)
      2'd0: begin
        if (rd_addr == A_CTRL) rd_data = ACC_W'({done, err, ready, go_q});
        else if (rd_addr == A_RES) rd_data = result;
      end
      2'd1: if (int'(ridx) < N) rd_data = ACC_W'(pix[ridx]);
      2'd2: if (int'(ridx) < N) rd_data = ACC_W'($unsigned(coef[ridx]));
      default: rd_data = '0;
    endcase
  end

  AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst) go_q |=> !go_q); // R7
  AST_MUL_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst) (go_q && op_q) |=> (mul_busy && !ready)); // R6
  AST_MUL_LENGTH: assert property (@(posedge clk) disable iff (rst) mul_last |=> (ready && done)); // R6
  AST_BUSY_GO_ERR: assert property (@(posedge clk) disable iff (rst) (go_req && !ready) |=> err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) (err && !(ctrl_wr && wr_data[2])) |=> err); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst) (rd_en && rd_addr == A_RES && !mul_last) |=> !done); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !mul_last |=> $stable(result)); // R10
  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (rst) !ready |=> $stable(coef[0])); // R11

endmodule

// File: tb/test_pixel_dot_classifier.sv
module test_pixel_dot_classifier;
  localparam int N = 16;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_CTRL = 6'h00, A_RES = 6'h01, A_PIX = 6'h10, A_COEF = 6'h20;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [31:0] rd_data;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pixel_dot_classifier i_pixel_dot_classifier (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  // fields: pixel slope, pixel offset, coef slope, coef offset
  localparam logic [63:0] VEC [6] = '{
    {16'd0,   16'd0,    16'd1,      16'd5},
    {16'd1,   16'd1,    16'd0,      16'd1},
    {16'd0,   16'd4095, 16'd0,      16'h7FFF},
    {16'd0,   16'd4095, 16'd0,      16'h8000},
    {16'd256, 16'd7,    16'hFFFD,   16'd100},
    {16'd300, 16'd4000, 16'd4001,   16'h8AD0}
  };

  function automatic logic [11:0] pix_val(logic [63:0] e, int i);
    return 12'(int'(e[63:48]) * i + int'(e[47:32]));
  endfunction
  function automatic logic [15:0] coef_val(logic [63:0] e, int i);
    return 16'(int'($signed(e[31:16])) * i + int'($signed(e[15:0])));
  endfunction
  function automatic longint dot_exp(logic [63:0] e);
    longint s = 0;
    for (int i = 0; i < N; i++)
      s += longint'(pix_val(e, i)) * longint'($signed(coef_val(e, i)));
    return s;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    rd_addr = a; rd_en = 1'b1; #1;
    d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; rd_addr = A_CTRL;
  endtask

  task automatic peek(logic [AW-1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data; rd_addr = A_CTRL;
  endtask

  task automatic load(logic [63:0] e, bit coefs);
    for (int i = 0; i < N; i++) begin
      if (coefs) wr(A_COEF + AW'(i), coef_val(e, i));
      wr(A_PIX + AW'(i), {4'd0, pix_val(e, i)});
    end
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    #1;
    while (!rd_data[1] && cyc < 1000) begin
      cyc++;
      @(negedge clk); #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int cyc;
    longint e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    peek(A_CTRL, d); check(d == 32'h2, "R1 ctrl after reset", d, 2);
    peek(A_RES, d);  check(d == 0, "R1 result after reset", d, 0);
    peek(A_PIX, d);  check(d == 0, "R1 pixel after reset", d, 0);
    peek(A_COEF + AW'(N-1), d); check(d == 0, "R1 R2 coef after reset", d, 0);

    foreach (VEC[k]) begin
      load(VEC[k], 1'b1);
      wr(A_CTRL, 16'h1);
      wait_ready(cyc); check(cyc == 1, "R6 store ready window", cyc, 1);
      peek(A_PIX + AW'(N-1), d);
      check(d == 32'(pix_val(VEC[k], N-1)), "R2 R4 stored pixel readback", d, pix_val(VEC[k], N-1));
      wr(A_CTRL, 16'h3);
      wait_ready(cyc); check(cyc == N+1, "R6 multiply ready window", cyc, N+1);
      e = dot_exp(VEC[k]);
      rd(A_RES, d); check(longint'($signed(d)) == e, "R5 dot product", longint'($signed(d)), e);
    end

    // R7 go self-clear
    wr(A_CTRL, 16'h1);
    peek(A_CTRL, d); check(d[0] == 1'b1, "R7 go pending", d[0], 1);
    @(negedge clk);
    peek(A_CTRL, d); check(d[0] == 1'b0, "R7 go cleared", d[0], 0);

    // R4 staging without store
    load(VEC[1], 1'b1);
    wr(A_CTRL, 16'h1); wait_ready(cyc);
    load(VEC[4], 1'b0);
    wr(A_CTRL, 16'h3); wait_ready(cyc);
    e = dot_exp(VEC[1]);
    peek(A_RES, d); check(longint'($signed(d)) == e, "R4 unstored staging ignored", longint'($signed(d)), e);

    // R9 done behaviour
    rd(A_CTRL, d); check(d[3] == 1'b1, "R9 done set", d[3], 1);
    peek(A_CTRL, d); check(d[3] == 1'b1, "R9 done survives ctrl read", d[3], 1);
    rd(A_RES, d);
    peek(A_CTRL, d); check(d[3] == 1'b0, "R9 done cleared by result read", d[3], 0);

    // R10 result not writable
    wr(A_RES, 16'hFFFF);
    peek(A_RES, d); check(longint'($signed(d)) == e, "R10 result write ignored", longint'($signed(d)), e);

    // R8 go while busy
    wr(A_CTRL, 16'h3);
    wr(A_CTRL, 16'h3);
    wait_ready(cyc); check(cyc + 1 == N+1, "R8 busy go ignored (window)", cyc + 1, N+1);
    peek(A_CTRL, d); check(d[2] == 1'b1, "R8 error set", d[2], 1);
    peek(A_RES, d); check(longint'($signed(d)) == e, "R8 result intact", longint'($signed(d)), e);
    wr(A_PIX, 16'h0); wr(A_CTRL, 16'h0);
    peek(A_CTRL, d); check(d[2] == 1'b1, "R8 error sticky", d[2], 1);
    wr(A_CTRL, 16'h4);
    peek(A_CTRL, d); check(d[2] == 1'b0, "R3 R8 error cleared", d[2], 0);

    // R11 coef write while busy
    peek(A_COEF, d);
    wr(A_CTRL, 16'h3);
    wr(A_COEF, 16'd1234);
    wait_ready(cyc);
    begin
      logic [31:0] d2;
      peek(A_COEF, d2); check(d2 == d, "R11 busy coef write ignored", d2, d);
    end

    // R1 reset after activity
    wr(A_CTRL, 16'h3); wr(A_CTRL, 16'h3);
    wait_ready(cyc);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    peek(A_CTRL, d); check(d == 32'h2, "R1 ctrl after mid reset", d, 2);
    peek(A_RES, d);  check(d == 0, "R1 result after mid reset", d, 0);
    peek(A_PIX + AW'(1), d); check(d == 0, "R1 pixel after mid reset", d, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule